// File: doc/BRIEF.md
# Compressed instruction expander

This block turns a 16-bit compressed RISC-V instruction into the equivalent 32-bit base instruction so that the rest of a decoder only ever sees the base format. The two low bits select a quadrant (00, 01 or 10); the value 11 marks a word that is already a 32-bit base instruction, and that word is forwarded untouched. All three quadrants are covered: loads and stores (including the floating-point forms), stack-pointer-relative accesses, immediate and shift forms, register-to-register ALU operations, jumps and conditional branches. The scrambled immediate bit orders of each compressed form are reassembled into the base I, S, B, U and J layouts.

The parameter `XLEN` (32 or 64) selects which meaning the encodings take where the two widths disagree. Reserved, non-standard and illegal encodings raise an illegal flag and produce an all-zero output word. Encodings set aside as hints expand to their base form and do not raise the flag. The translation itself is combinational; a valid strobe and the result are registered once, so a result appears one clock after its input.

Top module: `rvc_expander`

## Requirements
- R1: After reset `out_valid`, `out_instr` and `out_illegal` are 0. A word presented with `in_valid` high appears on the outputs after exactly one rising edge, with `out_valid` high. When `in_valid` is low, `out_valid` drops and `out_instr`/`out_illegal` keep their previous values.
- R2: When `in_instr[1:0]` is 11 the output equals the whole 32-bit input and `out_illegal` is 0. Every output that is not flagged illegal has bits [1:0] equal to 11.
- R3: A 3-bit compressed register field r names register 8+r, i.e. the 5-bit index {01, r}.
- R4: A 16-bit input of all zeros, and quadrant 00 funct3 000 (stack-pointer add) with a zero immediate, are illegal. Any illegal result drives `out_instr` to 0.
- R5: Quadrant 00 funct3 011 is a word float load (opcode 0000111, funct3 010) on XLEN 32 and a double-word integer load (opcode 0000011, funct3 011) on XLEN 64; funct3 111 is the matching float word store / double-word integer store. Quadrant 00 funct3 100 is reserved.
- R6: Quadrant 01 funct3 001 is a jump-and-link writing x1 on XLEN 32 and a 32-bit add-immediate (opcode 0011011) on XLEN 64, where a destination of x0 is reserved.
- R7: The jump offset in bits [12:2] (order 11,4,9:8,10,6,7,3:1,5) is sign-extended and emitted as JAL (opcode 1101111) with rd x0 for quadrant 01 funct3 101 and rd x1 for the XLEN-32 linking form.
- R8: Quadrant 01 funct3 110/111 expand to BEQ/BNE (opcode 1100011) of the compressed register against x0, with offset bits 8,4:3 in [12:10] and 7:6,2:1,5 in [6:2], sign-extended.
- R9: In quadrant 01 funct3 100, bits [11:10] = 00/01/10 give logical right shift, arithmetic right shift (funct7 0100000) and AND-immediate; 11 selects by {bit12, bits[6:5]}: 000 SUB, 001 XOR, 010 OR, 011 AND, and on XLEN 64 only 100 SUBW and 101 ADDW (opcode 0111011). All other combinations are reserved.
- R10: On XLEN 32 the right shifts and the quadrant 10 left shift are illegal when shift-amount bit 5 (bit 12) is set; on XLEN 64 that bit extends the shift amount.
- R11: Quadrant 01 funct3 011 with rd 2 adds a sign-extended multiple of 16 to x2; any other rd loads an upper immediate sign-extended from its bit 17. A zero immediate is reserved for both.
- R12: Quadrant 10 funct3 100 decodes by bit 12 and zero-ness of rs1 ([11:7]) and rs2 ([6:2]): jump to rs1 (rs1 of 0 reserved), move, breakpoint (output 0x00100073), jump-and-link to rs1, and add.
- R13: The stack-relative word load, and on XLEN 64 the double-word load, with rd 0 are reserved; the float stack-relative loads accept rd 0.
- R14: Hint encodings (destination x0 on immediate load, move, add) expand to their base form with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_instr | input | 32 | Instruction word; only [15:0] is used when [1:0] is not 11 |
| out_valid | output | 1 | Registered result is present |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | Input was a reserved, non-standard or illegal encoding |

## Verification
The hardest behaviour to reach from the ports is the width dependence: the same 16-bit word must be judged by two different rule sets, and a fault that swaps the XLEN-32 and XLEN-64 meaning only shows up when both are exercised on identical input. The bench therefore drives one stimulus into two instances, one per width, and each table entry carries an expected word and flag for each width. Encodings at the zero-field boundaries (zero immediate, rd of 0, rs1 of 0) sit next to their legal and hint neighbours in the table so that a wrong zero test in either direction is seen.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  localparam int ILEN = 32;
  localparam int CLEN = 16;

  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] OPC_LOADF   = 7'b0000111;
  localparam logic [6:0] OPC_STORE   = 7'b0100011;
  localparam logic [6:0] OPC_STOREF  = 7'b0100111;
  localparam logic [6:0] OPC_IMM     = 7'b0010011;
  localparam logic [6:0] OPC_IMM32   = 7'b0011011;
  localparam logic [6:0] OPC_REG     = 7'b0110011;
  localparam logic [6:0] OPC_REG32   = 7'b0111011;
  localparam logic [6:0] OPC_UPPER   = 7'b0110111;
  localparam logic [6:0] OPC_JAL     = 7'b1101111;
  localparam logic [6:0] OPC_JALR    = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
  localparam logic [ILEN-1:0] WORD_BREAK = 32'h00100073;

  typedef struct packed {
    logic [ILEN-1:0] word;
    logic            illegal;
  } xlat_t;

  // short register field -> full index
  function automatic logic [4:0] creg(input logic [2:0] r);
    return {2'b01, r};
  endfunction

  function automatic logic [ILEN-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                            input logic [2:0] f3, input logic [4:0] rd,
                                            input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [ILEN-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3,
                                            input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [ILEN-1:0] enc_b(input logic [12:0] imm, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [ILEN-1:0] enc_j(input logic [20:0] imm, input logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  function automatic logic [ILEN-1:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                            input logic [4:0] rs1, input logic [2:0] f3,
                                            input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

endpackage

// File: rtl/rvc_q0.sv
module rvc_q0 import rvc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [15:2] c,
  output xlat_t       res
);
  localparam bit IS64 = (XLEN == 64);

  logic [4:0] rd_s, rs1_s;
  logic [9:0] sp_add;
  logic [6:0] off_w;
  logic [7:0] off_d;

  assign rd_s   = creg(c[4:2]);
  assign rs1_s  = creg(c[9:7]);
  assign sp_add = {c[10:7], c[12:11], c[5], c[6], 2'b00};
  assign off_w  = {c[5], c[12:10], c[6], 2'b00};
  assign off_d  = {c[6:5], c[12:10], 3'b000};

  always_comb begin
    res = '{word: '0, illegal: 1'b0};
    case (c[15:13])
      3'b000: begin
        res.word    = enc_i({2'b00, sp_add}, 5'd2, 3'b000, rd_s, OPC_IMM);
        res.illegal = (sp_add == '0);
      end
      3'b001: res.word = enc_i({4'b0, off_d}, rs1_s, 3'b011, rd_s, OPC_LOADF);
      3'b010: res.word = enc_i({5'b0, off_w}, rs1_s, 3'b010, rd_s, OPC_LOAD);
      3'b011: res.word = IS64 ? enc_i({4'b0, off_d}, rs1_s, 3'b011, rd_s, OPC_LOAD)
                              : enc_i({5'b0, off_w}, rs1_s, 3'b010, rd_s, OPC_LOADF);
      3'b101: res.word = enc_s({4'b0, off_d}, rd_s, rs1_s, 3'b011, OPC_STOREF);
      3'b110: res.word = enc_s({5'b0, off_w}, rd_s, rs1_s, 3'b010, OPC_STORE);
      3'b111: res.word = IS64 ? enc_s({4'b0, off_d}, rd_s, rs1_s, 3'b011, OPC_STORE)
                              : enc_s({5'b0, off_w}, rd_s, rs1_s, 3'b010, OPC_STOREF);
      default: res.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvc_q1.sv
module rvc_q1 import rvc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [15:2] c,
  output xlat_t       res
);
  localparam bit IS64 = (XLEN == 64);

  logic [4:0]  rd, rd_s, rs2_s;
  logic [11:0] imm6;
  logic [11:0] sp16;
  logic [19:0] upper;
  logic [5:0]  shamt;
  logic [20:0] joff;
  logic [12:0] boff;

  assign rd    = c[11:7];
  assign rd_s  = creg(c[9:7]);
  assign rs2_s = creg(c[4:2]);
  assign imm6  = {{6{c[12]}}, c[12], c[6:2]};
  assign sp16  = {{2{c[12]}}, c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
  assign upper = {{14{c[12]}}, c[12], c[6:2]};
  assign shamt = {c[12], c[6:2]};
  assign joff  = {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign boff  = {{4{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};

  always_comb begin
    res = '{word: '0, illegal: 1'b0};
    case (c[15:13])
      3'b000: res.word = enc_i(imm6, rd, 3'b000, rd, OPC_IMM);
      3'b001: begin
        if (IS64) begin
          res.word    = enc_i(imm6, rd, 3'b000, rd, OPC_IMM32);
          res.illegal = (rd == 5'd0);
        end else begin
          res.word = enc_j(joff, 5'd1);
        end
      end
      3'b010: res.word = enc_i(imm6, 5'd0, 3'b000, rd, OPC_IMM);
      3'b011: begin
        if (rd == 5'd2) begin
          res.word    = enc_i(sp16, 5'd2, 3'b000, 5'd2, OPC_IMM);
          res.illegal = (sp16 == '0);
        end else begin
          res.word    = {upper, rd, OPC_UPPER};
          res.illegal = (shamt == '0);
        end
      end
      3'b100: begin
        case (c[11:10])
          2'b00: begin
            res.word    = enc_i({6'b000000, shamt}, rd_s, 3'b101, rd_s, OPC_IMM);
            res.illegal = !IS64 && c[12];
          end
          2'b01: begin
            res.word    = enc_i({6'b010000, shamt}, rd_s, 3'b101, rd_s, OPC_IMM);
            res.illegal = !IS64 && c[12];
          end
          2'b10: res.word = enc_i(imm6, rd_s, 3'b111, rd_s, OPC_IMM);
          default: begin
            case ({c[12], c[6:5]})
              3'b000: res.word = enc_r(7'b0100000, rs2_s, rd_s, 3'b000, rd_s, OPC_REG);
              3'b001: res.word = enc_r(7'b0000000, rs2_s, rd_s, 3'b100, rd_s, OPC_REG);
              3'b010: res.word = enc_r(7'b0000000, rs2_s, rd_s, 3'b110, rd_s, OPC_REG);
              3'b011: res.word = enc_r(7'b0000000, rs2_s, rd_s, 3'b111, rd_s, OPC_REG);
              3'b100: begin
                res.word    = enc_r(7'b0100000, rs2_s, rd_s, 3'b000, rd_s, OPC_REG32);
                res.illegal = !IS64;
              end
              3'b101: begin
                res.word    = enc_r(7'b0000000, rs2_s, rd_s, 3'b000, rd_s, OPC_REG32);
                res.illegal = !IS64;
              end
              default: res.illegal = 1'b1;
            endcase
          end
        endcase
      end
      3'b101: res.word = enc_j(joff, 5'd0);
      default: res.word = enc_b(boff, 5'd0, rd_s, {2'b00, c[13]});
    endcase
  end
endmodule

// File: rtl/rvc_q2.sv
module rvc_q2 import rvc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [15:2] c,
  output xlat_t       res
);
  localparam bit IS64 = (XLEN == 64);

  logic [4:0] rd, rs2;
  logic [5:0] shamt;
  logic [7:0] ld_w, st_w;
  logic [8:0] ld_d, st_d;

  assign rd    = c[11:7];
  assign rs2   = c[6:2];
  assign shamt = {c[12], c[6:2]};
  assign ld_w  = {c[3:2], c[12], c[6:4], 2'b00};
  assign ld_d  = {c[4:2], c[12], c[6:5], 3'b000};
  assign st_w  = {c[8:7], c[12:9], 2'b00};
  assign st_d  = {c[9:7], c[12:10], 3'b000};

  always_comb begin
    res = '{word: '0, illegal: 1'b0};
    case (c[15:13])
      3'b000: begin
        res.word    = enc_i({6'b000000, shamt}, rd, 3'b001, rd, OPC_IMM);
        res.illegal = !IS64 && c[12];
      end
      3'b001: res.word = enc_i({3'b0, ld_d}, 5'd2, 3'b011, rd, OPC_LOADF);
      3'b010: begin
        res.word    = enc_i({4'b0, ld_w}, 5'd2, 3'b010, rd, OPC_LOAD);
        res.illegal = (rd == 5'd0);
      end
      3'b011: begin
        if (IS64) begin
          res.word    = enc_i({3'b0, ld_d}, 5'd2, 3'b011, rd, OPC_LOAD);
          res.illegal = (rd == 5'd0);
        end else begin
          res.word = enc_i({4'b0, ld_w}, 5'd2, 3'b010, rd, OPC_LOADF);
        end
      end
      3'b100: begin
        if (!c[12]) begin
          if (rs2 == 5'd0) begin
            res.word    = enc_i(12'd0, rd, 3'b000, 5'd0, OPC_JALR);
            res.illegal = (rd == 5'd0);
          end else begin
            res.word = enc_r(7'd0, rs2, 5'd0, 3'b000, rd, OPC_REG);
          end
        end else if (rs2 != 5'd0) begin
          res.word = enc_r(7'd0, rs2, rd, 3'b000, rd, OPC_REG);
        end else if (rd == 5'd0) begin
          res.word = WORD_BREAK;
        end else begin
          res.word = enc_i(12'd0, rd, 3'b000, 5'd1, OPC_JALR);
        end
      end
      3'b101: res.word = enc_s({3'b0, st_d}, rs2, 5'd2, 3'b011, OPC_STOREF);
      3'b110: res.word = enc_s({4'b0, st_w}, rs2, 5'd2, 3'b010, OPC_STORE);
      default: res.word = IS64 ? enc_s({3'b0, st_d}, rs2, 5'd2, 3'b011, OPC_STORE)
                               : enc_s({4'b0, st_w}, rs2, 5'd2, 3'b010, OPC_STOREF);
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander import rvc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ILEN-1:0] in_instr,
  output logic            out_valid,
  output logic [ILEN-1:0] out_instr,
  output logic            out_illegal
);
  logic [1:0]      quad;
  xlat_t           res_q0, res_q1, res_q2, pick;
  logic [ILEN-1:0] nxt_word;
  logic            nxt_illegal;

  assign quad = in_instr[1:0];

  rvc_q0 #(.XLEN(XLEN)) u_q0 (.c(in_instr[CLEN-1:2]), .res(res_q0));
  rvc_q1 #(.XLEN(XLEN)) u_q1 (.c(in_instr[CLEN-1:2]), .res(res_q1));
  rvc_q2 #(.XLEN(XLEN)) u_q2 (.c(in_instr[CLEN-1:2]), .res(res_q2));

  always_comb begin
    case (quad)
      2'b00:   pick = res_q0;
      2'b01:   pick = res_q1;
      2'b10:   pick = res_q2;
      default: pick = '{word: in_instr, illegal: 1'b0};
    endcase
  end

  assign nxt_illegal = pick.illegal;
  assign nxt_word    = pick.illegal ? '0 : pick.word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_instr   <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_instr   <= nxt_word;
        out_illegal <= nxt_illegal;
      end
    end
  end
endmodule

// File: rtl/rvc_expander_chk.sv
module rvc_expander_chk #(
  parameter int XLEN = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_instr,
  input logic        out_valid,
  input logic [31:0] out_instr,
  input logic        out_illegal,
  input logic        nxt_illegal
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_instr) && $stable(out_illegal)));
  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[1:0] == 2'b11) |=> (out_instr == $past(in_instr) && !out_illegal));
  p_legal_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_instr[1:0] == 2'b11));
  p_zero_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[15:0] == 16'h0000) |=> out_illegal);
  p_ill_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_instr == 32'h0));
  p_flag_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_illegal == $past(nxt_illegal)));
  p_break_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[15:0] == 16'h9002) |=> (out_instr == 32'h00100073));
  p_shift32_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (XLEN == 32 && in_valid && in_instr[12] && in_instr[15:13] == 3'b000 &&
     in_instr[1:0] == 2'b10) |=> out_illegal);
endmodule

bind rvc_expander rvc_expander_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
  .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal),
  .nxt_illegal(nxt_illegal)
);

// File: tb/rvc_expander_bench.sv
module rvc_expander_bench;
  localparam int PERIOD = 10;
  localparam int NV = 39;

  // {input, req, word32, ill32, word64, ill64}
  localparam logic [101:0] VEC [NV] = '{
    {32'h00000040, 4'd3,  32'h00410413, 1'b0, 32'h00410413, 1'b0}, // R3 sp add into x8
    {32'h00000000, 4'd4,  32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R4 all zero
    {32'h00004144, 4'd3,  32'h00452483, 1'b0, 32'h00452483, 1'b0}, // R3 word load x9,4(x10)
    {32'h00006400, 4'd5,  32'h00842407, 1'b0, 32'h00843403, 1'b0}, // R5 float/dword load
    {32'h0000E400, 4'd5,  32'h00842427, 1'b0, 32'h00843423, 1'b0}, // R5 float/dword store
    {32'h00008000, 4'd5,  32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R5 reserved q0
    {32'h000010FD, 4'd9,  32'hFFF08093, 1'b0, 32'hFFF08093, 1'b0}, // R9 add imm -1
    {32'h00002085, 4'd6,  32'h060000EF, 1'b0, 32'h0010809B, 1'b0}, // R6 link jump / addiw
    {32'h00002005, 4'd6,  32'h020000EF, 1'b0, 32'h00000000, 1'b1}, // R6 addiw rd 0
    {32'h0000BFFD, 4'd7,  32'hFFFFF06F, 1'b0, 32'hFFFFF06F, 1'b0}, // R7 jump -2
    {32'h0000C801, 4'd8,  32'h00040863, 1'b0, 32'h00040863, 1'b0}, // R8 beq +16
    {32'h0000FCFD, 4'd8,  32'hFE049FE3, 1'b0, 32'hFE049FE3, 1'b0}, // R8 bne -2
    {32'h00008C05, 4'd9,  32'h40940433, 1'b0, 32'h40940433, 1'b0}, // R9 sub
    {32'h00008C65, 4'd9,  32'h00947433, 1'b0, 32'h00947433, 1'b0}, // R9 and
    {32'h00009C25, 4'd9,  32'h00000000, 1'b1, 32'h0094043B, 1'b0}, // R9 addw
    {32'h00009C45, 4'd9,  32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R9 reserved
    {32'h00009005, 4'd10, 32'h00000000, 1'b1, 32'h02145413, 1'b0}, // R10 srli 33
    {32'h00008405, 4'd9,  32'h40145413, 1'b0, 32'h40145413, 1'b0}, // R9 srai 1
    {32'h00006185, 4'd11, 32'h000011B7, 1'b0, 32'h000011B7, 1'b0}, // R11 upper 1
    {32'h00007181, 4'd11, 32'hFFFE01B7, 1'b0, 32'hFFFE01B7, 1'b0}, // R11 upper sign bit 17
    {32'h00006181, 4'd11, 32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R11 upper zero
    {32'h00006141, 4'd11, 32'h01010113, 1'b0, 32'h01010113, 1'b0}, // R11 sp +16
    {32'h00006101, 4'd11, 32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R11 sp zero
    {32'h00001082, 4'd10, 32'h00000000, 1'b1, 32'h02009093, 1'b0}, // R10 slli 32
    {32'h00004092, 4'd13, 32'h00412083, 1'b0, 32'h00412083, 1'b0}, // R13 stack word load
    {32'h00004012, 4'd13, 32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R13 rd 0
    {32'h00006012, 4'd13, 32'h00412007, 1'b0, 32'h00000000, 1'b1}, // R13 float ok / dword rd 0
    {32'h00008002, 4'd12, 32'h00000000, 1'b1, 32'h00000000, 1'b1}, // R12 jump rs1 0
    {32'h00008082, 4'd12, 32'h00008067, 1'b0, 32'h00008067, 1'b0}, // R12 jump x1
    {32'h00008426, 4'd12, 32'h00900433, 1'b0, 32'h00900433, 1'b0}, // R12 move
    {32'h00009002, 4'd12, 32'h00100073, 1'b0, 32'h00100073, 1'b0}, // R12 breakpoint
    {32'h00009082, 4'd12, 32'h000080E7, 1'b0, 32'h000080E7, 1'b0}, // R12 link x1
    {32'h00009426, 4'd12, 32'h00940433, 1'b0, 32'h00940433, 1'b0}, // R12 add
    {32'h00008026, 4'd14, 32'h00900033, 1'b0, 32'h00900033, 1'b0}, // R14 move to x0
    {32'h00004015, 4'd14, 32'h00500013, 1'b0, 32'h00500013, 1'b0}, // R14 imm to x0
    {32'h0000C426, 4'd9,  32'h00912423, 1'b0, 32'h00912423, 1'b0}, // R9 stack word store
    {32'h00A50513, 4'd2,  32'h00A50513, 1'b0, 32'h00A50513, 1'b0}, // R2 passthrough
    {32'h000020A2, 4'd13, 32'h00813087, 1'b0, 32'h00813087, 1'b0}, // R13 float dword stack load
    {32'h0000E426, 4'd5,  32'h00912427, 1'b0, 32'h00913423, 1'b0}  // R5 stack float/dword store
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic        v32, v64, i32, i64;
  logic [31:0] w32, w64;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rvc_expander #(.XLEN(32)) u_rvc_expander (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(v32), .out_instr(w32), .out_illegal(i32));

  rvc_expander #(.XLEN(64)) u_rvc_expander_64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(v64), .out_instr(w64), .out_illegal(i64));

  task automatic check(input string what, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = w;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 reset xlen32", {v32, w32}, 33'h0);
    check("R1 reset xlen64", {i64, w64}, 33'h0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][101:70]);
      check($sformatf("R%0d vector %0d xlen32", VEC[k][69:66], k), {i32, w32},
            {VEC[k][33], VEC[k][65:34]});
      check($sformatf("R%0d vector %0d xlen64", VEC[k][69:66], k), {i64, w64},
            {VEC[k][0], VEC[k][32:1]});
      check($sformatf("R1 valid after vector %0d", k), {32'h0, v32}, 33'h1);
    end

    // R1 hold: last result stays while valid is low, even with an illegal word present
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = 32'h0;
    @(negedge clk);
    check("R1 valid low", {32'h0, v32}, 33'h0);
    check("R1 hold xlen32", {i32, w32}, {1'b0, 32'h00912427});
    check("R1 hold xlen64", {i64, w64}, {1'b0, 32'h00913423});

    // R4 illegal after a legal result clears the word
    apply(32'h00008000);
    check("R4 clear after legal", {i32, w32}, {1'b1, 32'h0});

    // R1 reset in the middle of a stream
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", {v64, w64}, 33'h0);
    rst_n = 1'b1;
    apply(32'h00009002);
    check("R12 after reset", {i64, w64}, {1'b0, 32'h00100073});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule